// File: doc/BRIEF.md
# Staged Reset and Speed Control Port

This block is an 8-bit control register that sits on the host I/O bus at port 0x0CF9. Software uses it to pick between a processor-only (soft) reset and a whole-system (hard) reset. It also uses it to run the processor at reduced speed and to decide whether the processor self test runs when reset is applied. The block decodes a write strobe, a read strobe, a 16-bit port address, an access-size code and a data byte. It drives four outputs: a soft-reset pulse, a hard-reset pulse, a reduced-speed level and a self-test-enable level. A byte read at the port returns the stored bits.

A reset needs two writes. The first write stores the reset kind in bit 1 while bit 2 stays 0. The second write raises bit 2. The pulse fires only on the 0-to-1 change of the stored bit 2. The kind used is the one already held in the register, not the kind carried by the triggering write. The pulse lasts `PULSE_CYCLES` clocks. When a hard pulse ends, the whole register returns to zero.

Top module: `turbo_rst_ctrl`

## Requirements
- R1: A write is accepted only with `io_size_i` = 0 (byte) and `io_addr_i` = `PORT_ADDR` (0x0CF9). An accepted write stores data bits 3:0, and bits 7:4 always read as zero. A byte read at the same port asserts `io_rd_hit_o` and returns the stored byte on `io_rdata_o`.
- R2: Stored bit 0 drives `deturbo_o` and stored bit 3 drives `bist_en_o`, both from the clock edge that accepts the write.
- R3: A reset pulse starts on the clock edge after which stored bit 2 has gone from 0 to 1 through an accepted write. Both pulse outputs are low at any other start point.
- R4: The reset kind is the value of stored bit 1 before the triggering write. A 0 gives `soft_rst_o` and a 1 gives `hard_rst_o`. The two outputs are never high together.
- R5: Each reset pulse stays high for exactly `PULSE_CYCLES` clock cycles.
- R6: An accepted write with bit 2 = 1 while the stored bit 2 is already 1 fires no pulse. Writing bit 2 back to 0 re-arms the trigger.
- R7: On the edge that ends a hard pulse, all stored bits clear to zero. This takes priority over a write on the same edge. A soft pulse leaves the register unchanged.
- R8: Accesses with size 1 (word), 2 (dword) or 3 (reserved), at any address, are ignored. So are byte accesses at any other port. An ignored write changes no state and fires no pulse. An ignored read returns 0 with `io_rd_hit_o` low.
- R9: A 0-to-1 change of bit 2 that is accepted while a pulse is active is still stored, but it fires no second pulse.
- R10: While reset is held and after it is released, the register reads 0x00 and all four control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | ADDR_W | I/O port address |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata_i | input | 8 | Write data byte |
| io_rdata_o | output | 8 | Read data, zero when not hit |
| io_rd_hit_o | output | 1 | Read claimed by this port |
| soft_rst_o | output | 1 | Processor reset pulse |
| hard_rst_o | output | 1 | System reset pulse |
| deturbo_o | output | 1 | Reduced-speed select level |
| bist_en_o | output | 1 | Self test on reset enable level |

## Verification
Most internal faults show up one clock after a write.

- **Stuck or mis-stored register bit:** shows on `deturbo_o`, `bist_en_o` or the readback byte in the cycle after the write.
- **Wrong or missing edge memory:** shows as a pulse that fires twice for a repeated bit-2 write, or never fires after re-arming.
- **Wrong kind sampling:** shows in the first pulse cycle as the wrong output going high.
- **Off-by-one pulse counter:** shows only when the pulse falls, `PULSE_CYCLES` cycles after the start.
- **Missing hard-reset clear:** shows on the readback and level outputs in the cycle after the hard pulse ends.

// File: rtl/turbo_rst_pkg.sv
package turbo_rst_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_size_e;

  localparam int DATA_W = 8;
  localparam int CTL_W  = 4;

  // bit positions inside the stored byte
  localparam int B_SLOW = 0;
  localparam int B_HARD = 1;
  localparam int B_REQ  = 2;
  localparam int B_BIST = 3;

  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'((1 << CTL_W) - 1);
endpackage

// File: rtl/turbo_rst_decode.sv
module turbo_rst_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h0CF9)
) (
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [1:0]        io_size_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  import turbo_rst_pkg::*;

  logic sel;

  // only single-byte cycles at the exact port are claimed
  assign sel      = (io_addr_i == PORT_ADDR) && (acc_size_e'(io_size_i) == ACC_BYTE);
  assign wr_hit_o = io_wr_i && sel;
  assign rd_hit_o = io_rd_i && sel;
endmodule

// File: rtl/turbo_rst_regs.sv
module turbo_rst_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_hit_i,
  input  logic [7:0] wdata_i,
  input  logic       clear_i,
  input  logic       busy_i,
  output logic [7:0] ctl_o,
  output logic       fire_o,
  output logic       fire_hard_o
);
  import turbo_rst_pkg::*;

  logic [DATA_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (clear_i)  ctl_q <= '0;
    else if (wr_hit_i) ctl_q <= wdata_i & WR_MASK;
  end

  // edge of the request bit; kind comes from the value held before this write
  assign fire_o      = wr_hit_i && wdata_i[B_REQ] && !ctl_q[B_REQ] && !busy_i && !clear_i;
  assign fire_hard_o = ctl_q[B_HARD];
  assign ctl_o       = ctl_q;
endmodule

// File: rtl/turbo_rst_pulse.sv
module turbo_rst_pulse #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic hard_i,
  output logic soft_o,
  output logic hard_o,
  output logic busy_o,
  output logic hard_done_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= 1'b0;
    end else if (fire_i) begin
      cnt_q  <= CNT_LOAD;
      kind_q <= hard_i;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - CNT_ONE;
    end
  end

  assign busy_o      = (cnt_q != '0);
  assign soft_o      = busy_o && !kind_q;
  assign hard_o      = busy_o && kind_q;
  assign hard_done_o = hard_o && (cnt_q == CNT_ONE);
endmodule

// File: rtl/turbo_rst_ctrl.sv
module turbo_rst_ctrl #(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR    = ADDR_W'(16'h0CF9),
  parameter int                PULSE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [1:0]        io_size_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_rd_hit_o,
  output logic              soft_rst_o,
  output logic              hard_rst_o,
  output logic              deturbo_o,
  output logic              bist_en_o
);
  import turbo_rst_pkg::*;

  logic       wr_hit, rd_hit;
  logic [7:0] ctl;
  logic       fire, fire_hard, busy, hard_done;

  turbo_rst_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .io_wr_i  (io_wr_i),
    .io_rd_i  (io_rd_i),
    .io_addr_i(io_addr_i),
    .io_size_i(io_size_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  turbo_rst_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hit_i   (wr_hit),
    .wdata_i    (io_wdata_i),
    .clear_i    (hard_done),
    .busy_i     (busy),
    .ctl_o      (ctl),
    .fire_o     (fire),
    .fire_hard_o(fire_hard)
  );

  turbo_rst_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .hard_i     (fire_hard),
    .soft_o     (soft_rst_o),
    .hard_o     (hard_rst_o),
    .busy_o     (busy),
    .hard_done_o(hard_done)
  );

  assign io_rd_hit_o = rd_hit;
  assign io_rdata_o  = rd_hit ? ctl : '0;
  assign deturbo_o   = ctl[B_SLOW];
  assign bist_en_o   = ctl[B_BIST];
endmodule

// File: rtl/turbo_rst_ctrl_chk.sv
module turbo_rst_ctrl_chk #(
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR    = ADDR_W'(16'h0CF9),
  parameter int                PULSE_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [1:0]        io_size_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              soft_rst_o,
  input logic              hard_rst_o,
  input logic              deturbo_o,
  input logic              bist_en_o
);
  localparam int W_W = $clog2(PULSE_CYCLES + 2);

  logic           acc_wr, ign_wr, pulse;
  logic [W_W-1:0] width_q;

  assign acc_wr = io_wr_i && (io_addr_i == PORT_ADDR) && (io_size_i == 2'd0);
  assign ign_wr = io_wr_i && (io_size_i != 2'd0);
  assign pulse  = soft_rst_o || hard_rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    width_q <= '0;
    else if (pulse) width_q <= width_q + W_W'(1);
    else            width_q <= '0;
  end

  a_r1_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdata_o[7:4] == 4'h0);

  a_r2_slow_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && !hard_rst_o) |=> (deturbo_o == $past(io_wdata_i[0])) && (bist_en_o == $past(io_wdata_i[3])));

  a_r3_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(soft_rst_o) || $rose(hard_rst_o)) |-> $past(acc_wr && io_wdata_i[2]));

  a_r4_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_rst_o && hard_rst_o));

  a_r5_width_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_q <= W_W'(PULSE_CYCLES));

  a_r5_width_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse) |-> width_q == W_W'(PULSE_CYCLES));

  a_r7_hard_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hard_rst_o) |-> !deturbo_o && !bist_en_o);

  a_r8_ignored_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_wr && !io_wr_i == 1'b0 && !hard_rst_o && !pulse) |=> $stable(deturbo_o) && $stable(bist_en_o) && !pulse);
endmodule

bind turbo_rst_ctrl turbo_rst_ctrl_chk #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
  .io_size_i(io_size_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
  .soft_rst_o(soft_rst_o), .hard_rst_o(hard_rst_o), .deturbo_o(deturbo_o),
  .bist_en_o(bist_en_o)
);

// File: tb/turbo_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module turbo_rst_ctrl_tb_top;
  localparam int P = 6;
  localparam logic [15:0] PORT = 16'h0CF9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rd_hit, soft_rst, hard_rst, deturbo, bist_en;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  turbo_rst_ctrl #(.ADDR_W(16), .PORT_ADDR(PORT), .PULSE_CYCLES(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_size_i(io_size), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_rd_hit_o(io_rd_hit), .soft_rst_o(soft_rst),
    .hard_rst_o(hard_rst), .deturbo_o(deturbo), .bist_en_o(bist_en)
  );

  // {size[3:0], addr[15:0], wdata[7:0], expected stored low nibble[3:0]}
  localparam logic [31:0] VEC [10] = '{
    {4'd0, 16'h0CF9, 8'h01, 4'h1},
    {4'd0, 16'h0CF9, 8'h0A, 4'hA},
    {4'd0, 16'h0CF9, 8'hF9, 4'h9},
    {4'd1, 16'h0CF8, 8'h06, 4'h9},
    {4'd2, 16'h0CF8, 8'h0F, 4'h9},
    {4'd0, 16'h0CF8, 8'h00, 4'h9},
    {4'd0, 16'h0CFA, 8'h00, 4'h9},
    {4'd3, 16'h0CF9, 8'h00, 4'h9},
    {4'd0, 16'h0CF9, 8'h08, 4'h8},
    {4'd0, 16'h0CF9, 8'h00, 4'h0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [1:0] sz, input logic [15:0] a, input logic [7:0] d);
    io_wr = 1'b1; io_size = sz; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [15:0] a, output logic [7:0] d, output logic h);
    io_rd = 1'b1; io_size = sz; io_addr = a;
    #1;
    d = io_rdata; h = io_rd_hit;
    io_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic measure(output int n, output bit saw_soft, output bit saw_hard);
    n = 0; saw_soft = 0; saw_hard = 0;
    while ((soft_rst || hard_rst) && n < 40) begin
      if (soft_rst) saw_soft = 1;
      if (hard_rst) saw_hard = 1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int cycles, output bit any);
    any = 0;
    for (int i = 0; i < cycles; i++) begin
      if (soft_rst || hard_rst) any = 1;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic       h;
    int         n;
    bit         ss, sh, any;

    repeat (3) @(negedge clk);
    chk(!soft_rst && !hard_rst && !deturbo && !bist_en, "R10 outputs in reset",
        {soft_rst, hard_rst, deturbo, bist_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, PORT, d, h);
    chk(d == 8'h00 && h, "R10 readback after reset", d, 0);

    // R1 R2 R8: vector walk
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][29:28], VEC[i][27:12], VEC[i][11:4]);
      chk(!soft_rst && !hard_rst, "R8 no pulse in table", {soft_rst, hard_rst}, 0);
      chk(deturbo == VEC[i][0] && bist_en == VEC[i][3], "R2 level outputs",
          {bist_en, deturbo}, {VEC[i][3], VEC[i][0]});
      rd(2'd0, PORT, d, h);
      chk(h && d == {4'h0, VEC[i][3:0]}, "R1 readback", d, VEC[i][3:0]);
    end

    // R8: ignored reads
    rd(2'd1, 16'h0CF8, d, h);
    chk(!h && d == 0, "R8 word read ignored", {h, d}, 0);
    rd(2'd0, 16'h0CFA, d, h);
    chk(!h && d == 0, "R8 other port read", {h, d}, 0);

    // R8: wide write carrying a request bit fires nothing
    wr(2'd2, 16'h0CF8, 8'h04);
    quiet(P, any);
    chk(!any, "R8 dword write no trigger", any, 0);

    // R3 R4 R5: soft reset
    wr(2'd0, PORT, 8'h04);
    measure(n, ss, sh);
    chk(n == P && ss && !sh, "R5 soft pulse width", n, P);
    rd(2'd0, PORT, d, h);
    chk(d == 8'h04, "R7 soft keeps register", d, 4);

    // R6: repeat of bit 2 fires nothing
    wr(2'd0, PORT, 8'h04);
    quiet(P + 2, any);
    chk(!any, "R6 no retrigger", any, 0);

    // R4: kind from prior bit 1 (0), even though write carries 1
    wr(2'd0, PORT, 8'h00);
    wr(2'd0, PORT, 8'h06);
    measure(n, ss, sh);
    chk(n == P && ss && !sh, "R4 old kind soft", {sh, ss}, 1);

    // R4 R5 R7: hard reset
    wr(2'd0, PORT, 8'h0A);
    wr(2'd0, PORT, 8'h0F);
    chk(hard_rst && !soft_rst && deturbo, "R4 hard kind", {hard_rst, soft_rst, deturbo}, 5);
    measure(n, ss, sh);
    chk(n == P && sh && !ss, "R5 hard pulse width", n, P);
    chk(!deturbo && !bist_en, "R7 levels cleared", {deturbo, bist_en}, 0);
    rd(2'd0, PORT, d, h);
    chk(d == 8'h00, "R7 register cleared", d, 0);

    // R9: retrigger during active pulse
    wr(2'd0, PORT, 8'h04);
    chk(soft_rst, "R3 soft starts", soft_rst, 1);
    wr(2'd0, PORT, 8'h00);
    wr(2'd0, PORT, 8'h04);
    measure(n, ss, sh);
    chk(n == P - 2, "R9 remaining width", n, P - 2);
    quiet(P + 2, any);
    chk(!any, "R9 no second pulse", any, 0);
    rd(2'd0, PORT, d, h);
    chk(d == 8'h04, "R9 bit stored", d, 4);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule